// File: doc/BRIEF.md
# Activity LED pulse stretcher

This block turns brief activity strobes into LED drive levels that a person can see. It has eight port-activity channels and one collision channel. Each channel takes a strobe that may last one clock or many, and drives an active-low output. A strobe seen while the channel is idle lights the LED for a guaranteed minimum on period. A guaranteed dark gap always follows, so steady traffic shows as a blink and not as a solid light.

All channels count a shared tick of one millisecond. A single prescaler makes this tick from the system clock, and its divisor is a parameter so that a simulation can shorten it. A strobe that comes during the dark gap is remembered and starts the next on period as soon as the gap ends. A strobe that comes during an on period is dropped. Reset puts every channel into the idle state with its LED dark.

Top module: `led_stretch_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe applied, every output is 1 (dark). A reset applied during an on period forces the output to 1, and no on period follows it without a new strobe.
- R2: Outputs are active low. A strobe sampled high at a rising clock edge while its channel is idle drives that channel's output to 0 from that same edge.
- R3: An on period (output 0) lasts at least ON_MS*TICK_DIV and at most (ON_MS+1)*TICK_DIV clock cycles. The shared tick is high for one cycle in every TICK_DIV cycles.
- R4: Between the end of one on period and the start of the next on the same channel, the output stays 1 for at least OFF_MS*TICK_DIV clock cycles.
- R5: A strobe that comes during the dark gap is latched. The next on period then starts so that the gap is no longer than (OFF_MS+1)*TICK_DIV cycles.
- R6: A strobe during an on period neither extends it beyond the R3 bound nor is stored. With no further strobe, the output stays 1 once that period has ended.
- R7: Channels are independent. A strobe on one channel changes no other channel's output.
- R8: The collision channel (`col_i` and `col_led_n_o`) follows the same R2 to R6 timing as the port channels.
- R9: A strobe held high keeps producing on periods, each separated by a gap no longer than (OFF_MS+1)*TICK_DIV cycles. After the strobe is released during an on period, no further on period follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_i | input | NUM_PORTS | Per-port activity strobes, active high |
| col_i | input | 1 | Collision strobe, active high |
| act_led_n_o | output | NUM_PORTS | Per-port activity LED drive, 0 = lit |
| col_led_n_o | output | 1 | Collision LED drive, 0 = lit |

## Verification
The critical coincidence is a strobe that is present in the very cycle the dark gap expires. In that cycle the channel must combine the gap-end decision with the newly arriving event, and it must restart without losing the event and without shortening the gap. The bench provokes this by holding one channel's strobe high across several periods, so a strobe is present at every gap expiry. It judges the result by measuring each gap against both its lower and upper bounds and by confirming that exactly the expected number of on periods appears. A second coincidence is a strobe arriving while the tick fires at the end of an on period. Single strobes are placed at several offsets inside on periods, and the bench checks that no extra period follows.

// File: rtl/led_stretch_pkg.sv
// Package: shared types for the LED pulse stretcher.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package led_stretch_pkg;

    // Channel sequencing states: dark and waiting, lit, mandatory dark gap.
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_ON   = 2'd1,
        CH_GAP  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/led_ms_tick.sv
// Module: led_ms_tick
// Makes a one-cycle tick every TICK_DIV clocks; shared by all LED channels.
// Assumes: TICK_DIV >= 2; synchronous active-low reset restarts the count.
module led_ms_tick #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(TICK_DIV);

    logic [CW-1:0] div_q;

    // Free-running divider that wraps after TICK_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == CW'(TICK_DIV - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Tick marks the last cycle of each divider period.
    always_comb begin
        tick_o = (div_q == CW'(TICK_DIV - 1));
    end

endmodule

// File: rtl/led_channel.sv
// Module: led_channel
// One LED stretcher: idle -> on for ON_MS+1 ticks -> dark gap for OFF_MS+1
// ticks -> idle or on again if an event was seen during the gap.
// Assumes: tick_i is one cycle wide; evt_i is synchronous to clk.
module led_channel
    import led_stretch_pkg::*;
#(
    parameter int ON_MS  = 80,
    parameter int OFF_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic evt_i,
    output logic led_n_o
);
    localparam int MAXC = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
    localparam int CW   = $clog2(MAXC + 1);

    ch_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pend_q, pend_d;

    // Next-state logic for the on / gap sequencing and the pending flag.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        unique case (state_q)
            CH_IDLE: begin
                if (evt_i) begin
                    state_d = CH_ON;
                    cnt_d   = '0;
                end
            end
            CH_ON: begin
                if (tick_i) begin
                    if (cnt_q == CW'(ON_MS)) begin
                        state_d = CH_GAP;
                        cnt_d   = '0;
                        pend_d  = 1'b0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CH_GAP: begin
                pend_d = pend_q | evt_i;
                if (tick_i) begin
                    if (cnt_q == CW'(OFF_MS)) begin
                        cnt_d   = '0;
                        pend_d  = 1'b0;
                        state_d = (pend_q | evt_i) ? CH_ON : CH_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = CH_IDLE;
                cnt_d   = '0;
                pend_d  = 1'b0;
            end
        endcase
    end

    // State, tick counter and pending flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    // LED is lit (low) only in the on state.
    always_comb begin
        led_n_o = (state_q != CH_ON);
    end

endmodule

// File: rtl/led_stretch_top.sv
// Module: led_stretch_top
// Eight (NUM_PORTS) activity LED stretchers plus one collision stretcher,
// all timed from one shared millisecond tick.
// Assumes: strobes are already synchronous to clk.
module led_stretch_top #(
    parameter int NUM_PORTS = 8,
    parameter int TICK_DIV  = 50000,
    parameter int ON_MS     = 80,
    parameter int OFF_MS    = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] act_i,
    input  logic                 col_i,
    output logic [NUM_PORTS-1:0] act_led_n_o,
    output logic                 col_led_n_o
);
    logic w_tick;

    // Shared prescaler.
    led_ms_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (w_tick)
    );

    // One stretcher per port.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        led_channel #(.ON_MS(ON_MS), .OFF_MS(OFF_MS)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (w_tick),
            .evt_i   (act_i[g]),
            .led_n_o (act_led_n_o[g])
        );
    end

    // Collision stretcher with the same timing.
    led_channel #(.ON_MS(ON_MS), .OFF_MS(OFF_MS)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (w_tick),
        .evt_i   (col_i),
        .led_n_o (col_led_n_o)
    );

endmodule

// File: rtl/led_stretch_chk.sv
// Module: led_stretch_chk
// Checker for led_stretch_top: tick spacing, on/off period bounds, reset.
// Assumes: bound to led_stretch_top; leds = {collision, ports}.
module led_stretch_chk #(
    parameter int NUM_PORTS = 8,
    parameter int TICK_DIV  = 50000,
    parameter int ON_MS     = 80,
    parameter int OFF_MS    = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NUM_PORTS:0]   leds
);
    localparam int NCH = NUM_PORTS + 1;

    int unsigned tick_gap;

    // Cycles since the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     tick_gap <= 0;
        else if (tick)  tick_gap <= 0;
        else            tick_gap <= tick_gap + 1;
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (tick_gap == TICK_DIV - 1)); // R3
    AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_gap <= TICK_DIV - 1); // R3
    AST_RESET_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&leds)); // R1

    for (genvar c = 0; c < NCH; c++) begin : g_c
        int unsigned low_len, high_len;
        logic        prev_q, was_on_q;

        // Track the length of the current lit and dark stretch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                low_len  <= 0;
                high_len <= 0;
                prev_q   <= 1'b1;
                was_on_q <= 1'b0;
            end else begin
                prev_q <= leds[c];
                if (!leds[c]) begin
                    low_len  <= low_len + 1;
                    high_len <= 0;
                    was_on_q <= 1'b1;
                end else begin
                    low_len  <= 0;
                    high_len <= high_len + 1;
                end
            end
        end

        AST_ON_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            (!prev_q && leds[c]) |-> (low_len >= ON_MS * TICK_DIV)); // R3
        AST_ON_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            !leds[c] |-> (low_len < (ON_MS + 1) * TICK_DIV)); // R3
        AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_q && !leds[c] && was_on_q) |-> (high_len >= OFF_MS * TICK_DIV)); // R4
    end

endmodule

bind led_stretch_top led_stretch_chk #(
    .NUM_PORTS (NUM_PORTS),
    .TICK_DIV  (TICK_DIV),
    .ON_MS     (ON_MS),
    .OFF_MS    (OFF_MS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (w_tick),
    .leds  ({col_led_n_o, act_led_n_o})
);

// File: tb/test_led_stretch_top.sv
// Bench: scoreboard of expected on periods; a monitor measures every lit
// and dark stretch on all nine outputs and pops the queue per lit period.
module test_led_stretch_top;
    localparam int NP   = 8;
    localparam int DIV  = 10;
    localparam int ONM  = 4;
    localparam int OFFM = 2;
    localparam int NCH  = NP + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] act = '0;
    logic          col = 1'b0;
    logic [NP-1:0] act_led_n;
    logic          col_led_n;
    logic [NCH-1:0] leds;

    assign leds = {col_led_n, act_led_n};

    led_stretch_top #(.NUM_PORTS(NP), .TICK_DIV(DIV), .ON_MS(ONM), .OFF_MS(OFFM))
    i_led_stretch_top (
        .clk(clk), .rst_n(rst_n), .act_i(act), .col_i(col),
        .act_led_n_o(act_led_n), .col_led_n_o(col_led_n)
    );

    always #10 clk = ~clk; // 50 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    int    exp_q[$];
    string req_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic expect_pulse(input int ch, input string req);
        exp_q.push_back(ch);
        req_q.push_back(req);
    endtask

    task automatic set_in(input int ch, input logic v);
        if (ch == NP) col = v;
        else act[ch] = v;
    endtask

    task automatic strobe(input int ch, input int len);
        @(posedge clk); #1 set_in(ch, 1'b1);
        repeat (len) @(posedge clk);
        #1 set_in(ch, 1'b0);
    endtask

    task automatic wait_idle();
        repeat ((ONM + OFFM + 4) * DIV) @(posedge clk);
    endtask

    // Monitor: measure each stretch and compare completed lit periods.
    int  low_len [NCH];
    int  high_len[NCH];
    bit  prev_l  [NCH];
    bit  was_on  [NCH];
    always @(negedge clk) begin
        for (int ch = 0; ch < NCH; ch++) begin
            if (!rst_n) begin
                low_len[ch] = 0; high_len[ch] = 0; prev_l[ch] = 1'b1; was_on[ch] = 1'b0;
            end else if (leds[ch] == 1'b0) begin
                if (prev_l[ch] && was_on[ch])
                    check(high_len[ch] >= OFFM * DIV, "R4", "gap length", high_len[ch], OFFM * DIV);
                low_len[ch]++;
                high_len[ch] = 0;
                was_on[ch] = 1'b1;
                prev_l[ch] = 1'b0;
            end else begin
                if (!prev_l[ch]) begin
                    check(low_len[ch] >= ONM * DIV && low_len[ch] <= (ONM + 1) * DIV,
                          "R3", "on length", low_len[ch], ONM * DIV);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", "unexpected on period on channel", ch, -1);
                    end else begin
                        int    e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        check(e == ch, r, "on period channel", ch, e);
                    end
                end
                low_len[ch] = 0;
                high_len[ch]++;
                prev_l[ch] = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL all requirements: watchdog expired, actual cycle %0d expected done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t_rise, t_fall;
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(leds == '1, "R1", "outputs in reset", int'(leds), (1 << NCH) - 1);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (100) @(posedge clk);
        @(negedge clk);
        check(leds == '1, "R1", "outputs after reset", int'(leds), (1 << NCH) - 1);

        // R2, R7: single-cycle strobe on port 0.
        expect_pulse(0, "R2");
        @(posedge clk); #1 act[0] = 1'b1;
        @(posedge clk); #1 act[0] = 1'b0;
        @(negedge clk);
        check(leds[0] == 1'b0, "R2", "port 0 lit after strobe", leds[0], 0);
        check(leds[NCH-1:1] == '1, "R7", "other outputs dark", int'(leds[NCH-1:1]), (1 << (NCH - 1)) - 1);
        wait_idle();

        // R6: strobes during the on period are dropped.
        expect_pulse(3, "R6");
        strobe(3, 1);
        repeat (7) @(posedge clk);
        strobe(3, 2);
        repeat (ONM * DIV - 15) @(posedge clk);
        strobe(3, 1);
        wait_idle();
        @(negedge clk);
        check(leds[3] == 1'b1, "R6", "port 3 dark after dropped strobes", leds[3], 1);

        // R5: strobe during the gap is latched.
        expect_pulse(5, "R5");
        expect_pulse(5, "R5");
        strobe(5, 1);
        do @(negedge clk); while (leds[5] !== 1'b1);
        t_rise = cyc;
        repeat (3) @(posedge clk);
        strobe(5, 1);
        do @(negedge clk); while (leds[5] !== 1'b0);
        t_fall = cyc;
        check(t_fall - t_rise >= OFFM * DIV && t_fall - t_rise <= (OFFM + 1) * DIV,
              "R5", "gap before latched period", t_fall - t_rise, OFFM * DIV);
        wait_idle();

        // R8: collision channel.
        expect_pulse(NP, "R8");
        strobe(NP, 3);
        @(negedge clk);
        check(leds[NP] == 1'b0, "R8", "collision lit", leds[NP], 0);
        wait_idle();

        // R9: held strobe blinks; gap expiry coincides with a present strobe.
        for (int k = 0; k < 3; k++) expect_pulse(7, "R9");
        @(posedge clk); #1 act[7] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            do @(negedge clk); while (leds[7] !== 1'b0);
            t_fall = cyc;
            if (k > 0)
                check(t_fall - t_rise <= (OFFM + 1) * DIV, "R9", "restart gap", t_fall - t_rise, (OFFM + 1) * DIV);
            if (k < 2) begin
                do @(negedge clk); while (leds[7] !== 1'b1);
                t_rise = cyc;
            end
        end
        @(posedge clk); #1 act[7] = 1'b0;
        wait_idle();
        @(negedge clk);
        check(leds[7] == 1'b1, "R9", "dark after release", leds[7], 1);

        // R7: several channels together.
        expect_pulse(1, "R7"); expect_pulse(2, "R7");
        expect_pulse(4, "R7"); expect_pulse(6, "R7");
        @(posedge clk); #1 act = 8'b0101_0110;
        repeat (3) @(posedge clk);
        #1 act = '0;
        @(negedge clk);
        check(leds == 9'b1_1010_1001, "R7", "selected channels lit", int'(leds), 9'b1_1010_1001);
        wait_idle();

        // R1: reset during an on period.
        strobe(0, 1);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(leds[0] == 1'b1, "R1", "port 0 dark in reset", leds[0], 1);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_idle();
        @(negedge clk);
        check(leds == '1, "R1", "no period after reset", int'(leds), (1 << NCH) - 1);
        check(exp_q.size() == 0, "R5", "expected periods outstanding", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule